// File: doc/BRIEF.md
# Predicate Register File with Boolean and Reduce Unit

This block holds sixteen 64-bit predicate masks, one bit per byte lane of a wide vector datapath. Each issued instruction carries an opcode, two 4-bit source indices and a 4-bit destination index. Logic opcodes combine masks bit by bit across the whole register and write the result back. Reduce opcodes fold one mask into a single scalar flag: "every considered bit set" or "any considered bit set".

A lane-size mode picks which bits a reduce considers: every bit for byte lanes, every second bit for 16-bit lanes, every fourth bit for 32-bit lanes. A separate load port lets an outside producer, such as a compare unit, fill a register. A read port exposes any register. The read port and the source operands both see the newest value, including one being written in the same cycle.

Logic results pass through one register stage. An instruction issued at a clock edge has its result visible to reads in the following cycle through the bypass, and it lands in the file at the next edge. A dependent instruction can therefore follow back to back.

Top module: `pred_bool_file`

## Requirements
- R1: On reset every register reads zero and `red_valid`, `red_bit` and `illegal` are 0.
- R2: A load (`ld_we`=1) writes `ld_data` into register `ld_idx`; the value reads back on `rd_data` at `rd_idx` in later cycles.
- R3: Logic opcodes write the destination with the following results: 0 = A&B, 1 = A|B, 2 = A^B, 3 = ~A, 5 = A|~B, 6 = A. Each acts on all 64 bits with no lane boundaries.
- R4: Opcode 4 writes A&~B; the second source is the one inverted. A logic result is registered at its issue edge and is readable in the next cycle, so a dependent opcode issued in that cycle uses it. A logic opcode raises neither `red_valid` nor `illegal`.
- R5: Opcodes 9 to 15 are illegal, and this covers the slot an XOR-NOT would take. An illegal opcode writes no register and gives no reduce. It sets `illegal` for one cycle, the cycle after issue.
- R6: Opcode 7 (reduce-all) sets `red_valid` for one cycle, the cycle after issue. `red_bit` is 1 only when every considered bit of source A is set. A reduce writes no register.
- R7: Opcode 8 (reduce-any) sets `red_valid` in the same way. `red_bit` is 1 when at least one considered bit is set. `red_bit` is 0 whenever `red_valid` is 0.
- R8: A reduce uses `lane_mode` to pick its bits: 0 = all 64 bits (both 32-bit halves), 1 = even bits (2k), 2 = bits 4k. A reduce with mode 3 is illegal.
- R9: A read of a register that is being loaded or written back in the same cycle returns the new value. When a logic writeback and a load target the same register at the same edge, the logic writeback wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction issue strobe |
| op_code | input | 4 | Opcode |
| src_a | input | 4 | First source index |
| src_b | input | 4 | Second source index |
| dst | input | 4 | Destination index |
| lane_mode | input | 2 | Reduce lane-size mode |
| ld_we | input | 1 | External load strobe |
| ld_idx | input | 4 | External load index |
| ld_data | input | 64 | External load value |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 64 | Read port value (bypassed) |
| red_valid | output | 1 | Reduce result strobe |
| red_bit | output | 1 | Reduce result |
| illegal | output | 1 | Illegal instruction pulse |

## Verification
The assertions check the following on every cycle: the one-cycle response pattern of each opcode class (logic, reduce, illegal, and a reduce with mode 3), that `red_bit` is only high alongside `red_valid`, and that the read port forwards a same-cycle load. Only the bench scenarios can show the actual mask values. These include the result of each logic opcode, the direction of the inverted operand in AND-NOT, and the all-set and any-set answers under each lane mode. They also include the back-to-back dependency, the writeback-over-load priority, and that illegal and reduce opcodes leave the destination register untouched.

// File: rtl/pred_bool_file.sv
module pred_bool_file #(
  parameter int NREG = 16,
  parameter int W    = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [3:0]              op_code,
  input  logic [$clog2(NREG)-1:0] src_a,
  input  logic [$clog2(NREG)-1:0] src_b,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic [1:0]              lane_mode,
  input  logic                    ld_we,
  input  logic [$clog2(NREG)-1:0] ld_idx,
  input  logic [W-1:0]            ld_data,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [W-1:0]            rd_data,
  output logic                    red_valid,
  output logic                    red_bit,
  output logic                    illegal
);
  localparam int IW = $clog2(NREG);
  localparam logic [3:0] OP_AND  = 4'd0;
  localparam logic [3:0] OP_OR   = 4'd1;
  localparam logic [3:0] OP_XOR  = 4'd2;
  localparam logic [3:0] OP_NOT  = 4'd3;
  localparam logic [3:0] OP_ANDN = 4'd4;
  localparam logic [3:0] OP_ORN  = 4'd5;
  localparam logic [3:0] OP_MOV  = 4'd6;
  localparam logic [3:0] OP_RALL = 4'd7;
  localparam logic [3:0] OP_RANY = 4'd8;

  logic [W-1:0]  regs [NREG];
  logic [W-1:0]  view [NREG];
  logic          wb_v;
  logic [IW-1:0] wb_idx;
  logic [W-1:0]  wb_data;

  logic [W-1:0] mask_half, mask_word, red_mask;
  logic [W-1:0] a_val, b_val, res;
  logic         is_logic, is_red, all_set, any_set;

  for (genvar i = 0; i < NREG; i++) begin : g_view
    assign view[i] = (wb_v && wb_idx == IW'(i)) ? wb_data :
                     (ld_we && ld_idx == IW'(i)) ? ld_data : regs[i];
  end

  for (genvar b = 0; b < W; b++) begin : g_mask
    assign mask_half[b] = (b % 2 == 0);
    assign mask_word[b] = (b % 4 == 0);
  end

  assign a_val   = view[src_a];
  assign b_val   = view[src_b];
  assign rd_data = view[rd_idx];

  always_comb begin
    case (lane_mode)
      2'd0:    red_mask = '1;
      2'd1:    red_mask = mask_half;
      2'd2:    red_mask = mask_word;
      default: red_mask = '0;
    endcase
  end

  assign is_logic = (op_code <= OP_MOV);
  assign is_red   = (op_code == OP_RALL || op_code == OP_RANY) && lane_mode != 2'd3;
  assign all_set  = &(a_val | ~red_mask);
  assign any_set  = |(a_val & red_mask);

  always_comb begin
    case (op_code)
      OP_AND:  res = a_val & b_val;
      OP_OR:   res = a_val | b_val;
      OP_XOR:  res = a_val ^ b_val;
      OP_NOT:  res = ~a_val;
      OP_ANDN: res = a_val & ~b_val;
      OP_ORN:  res = a_val | ~b_val;
      default: res = a_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_v      <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      red_valid <= 1'b0;
      red_bit   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      wb_v      <= op_valid && is_logic;
      wb_idx    <= dst;
      wb_data   <= res;
      red_valid <= op_valid && is_red;
      red_bit   <= op_valid && is_red && ((op_code == OP_RALL) ? all_set : any_set);
      illegal   <= op_valid && !is_logic && !is_red;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wb_v && wb_idx == IW'(i))       regs[i] <= wb_data;
        else if (ld_we && ld_idx == IW'(i)) regs[i] <= ld_data;
      end
    end
  end
endmodule

// File: rtl/pred_bool_file_chk.sv
module pred_bool_file_chk #(
  parameter int IW = 4,
  parameter int W  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [1:0]    lane_mode,
  input logic          ld_we,
  input logic [IW-1:0] ld_idx,
  input logic [W-1:0]  ld_data,
  input logic [IW-1:0] rd_idx,
  input logic [W-1:0]  rd_data,
  input logic          wb_v,
  input logic [IW-1:0] wb_idx,
  input logic          red_valid,
  input logic          red_bit,
  input logic          illegal
);
  assert_logic_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code <= 4'd6 |=> wb_v && !red_valid && !illegal);

  assert_illegal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code >= 4'd9 |=> illegal && !red_valid && !wb_v);

  assert_reduce_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 4'd7 || op_code == 4'd8) && lane_mode != 2'd3
    |=> red_valid && !illegal && !wb_v);

  assert_bit_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    red_bit |-> red_valid);

  assert_mode3_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 4'd7 || op_code == 4'd8) && lane_mode == 2'd3
    |=> illegal && !red_valid);

  assert_load_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we && rd_idx == ld_idx && !(wb_v && wb_idx == ld_idx) |-> rd_data == ld_data);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({red_valid, illegal, wb_v}));
endmodule

bind pred_bool_file pred_bool_file_chk #(.IW(IW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .lane_mode(lane_mode), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .wb_v(wb_v), .wb_idx(wb_idx),
  .red_valid(red_valid), .red_bit(red_bit), .illegal(illegal)
);

// File: tb/pred_bool_file_tb.sv
module pred_bool_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0, src_a = '0, src_b = '0, dst = '0, ld_idx = '0, rd_idx = '0;
  logic [1:0]  lane_mode = '0;
  logic        ld_we = 1'b0;
  logic [63:0] ld_data = '0;
  logic [63:0] rd_data;
  logic        red_valid, red_bit, illegal;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [63:0] VA = 64'hF0F0_1234_FFFF_0000;
  localparam logic [63:0] VB = 64'h0FF0_00FF_AAAA_5555;
  localparam logic [63:0] VC = 64'h8000_0000_0000_0001;

  always #4 clk = ~clk;

  pred_bool_file u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .dst(dst), .lane_mode(lane_mode),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .red_valid(red_valid), .red_bit(red_bit), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] idx, output logic [63:0] v);
    rd_idx = idx;
    #1;
    v = rd_data;
  endtask

  task automatic load(input logic [3:0] idx, input logic [63:0] v);
    logic [63:0] r;
    @(negedge clk);
    ld_we = 1'b1; ld_idx = idx; ld_data = v;
    peek(idx, r);
    check("R9 same-cycle load bypass", r, v);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic issue(input logic [3:0] c, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] d, input logic [1:0] m);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; src_a = a; src_b = b; dst = d; lane_mode = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] r;
    for (int i = 0; i < 16; i++) begin
      peek(4'(i), r);
      check("R1 register zero after reset", r, 64'd0);
    end
    check("R1 red_valid low", {63'd0, red_valid}, 64'd0);
    check("R1 red_bit low", {63'd0, red_bit}, 64'd0);
    check("R1 illegal low", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_load;
    logic [63:0] r;
    load(4'd1, VA);
    load(4'd2, VB);
    load(4'd3, VC);
    load(4'd15, 64'h0123_4567_89AB_CDEF);
    peek(4'd1, r);  check("R2 load r1", r, VA);
    peek(4'd2, r);  check("R2 load r2", r, VB);
    peek(4'd15, r); check("R2 load r15", r, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic logic_case(input string tag, input logic [3:0] c, input logic [63:0] exp);
    logic [63:0] r;
    issue(c, 4'd1, 4'd2, 4'd4, 2'd0);
    check({tag, " no reduce strobe"}, {63'd0, red_valid | illegal}, 64'd0);
    peek(4'd4, r);
    check({tag, " next-cycle value"}, r, exp);
    @(negedge clk);
    peek(4'd4, r);
    check({tag, " settled in file"}, r, exp);
  endtask

  task automatic t_logic;
    logic_case("R3 AND", 4'd0, VA & VB);
    logic_case("R3 OR", 4'd1, VA | VB);
    logic_case("R3 XOR", 4'd2, VA ^ VB);
    logic_case("R3 NOT", 4'd3, ~VA);
    logic_case("R4 AND-NOT inverts B", 4'd4, VA & ~VB);
    logic_case("R3 OR-NOT", 4'd5, VA | ~VB);
    logic_case("R3 MOVE", 4'd6, VA);
  endtask

  task automatic t_andn_swap;
    logic [63:0] r;
    issue(4'd4, 4'd2, 4'd1, 4'd4, 2'd0);
    peek(4'd4, r);
    check("R4 AND-NOT swapped operands", r, VB & ~VA);
  endtask

  task automatic t_back_to_back;
    logic [63:0] r;
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd0; src_a = 4'd1; src_b = 4'd2; dst = 4'd5; lane_mode = 2'd0;
    @(negedge clk);
    op_code = 4'd1; src_a = 4'd5; src_b = 4'd3; dst = 4'd6;
    @(negedge clk);
    op_valid = 1'b0;
    peek(4'd6, r);
    check("R4 dependent op uses fresh result", r, (VA & VB) | VC);
    @(negedge clk);
    peek(4'd5, r);
    check("R4 first result kept", r, VA & VB);
  endtask

  task automatic t_illegal;
    logic [63:0] r;
    load(4'd7, 64'hDEAD_BEEF_0000_FFFF);
    for (int c = 9; c < 16; c++) begin
      issue(4'(c), 4'd1, 4'd2, 4'd7, 2'd0);
      check("R5 illegal pulse", {63'd0, illegal}, 64'd1);
      check("R5 no reduce on illegal", {63'd0, red_valid}, 64'd0);
      @(negedge clk);
      check("R5 illegal pulse one cycle", {63'd0, illegal}, 64'd0);
      peek(4'd7, r);
      check("R5 destination untouched", r, 64'hDEAD_BEEF_0000_FFFF);
    end
  endtask

  task automatic reduce_case(input string tag, input logic [63:0] v, input logic [3:0] c,
                             input logic [1:0] m, input logic exp);
    logic [63:0] r;
    load(4'd10, v);
    issue(c, 4'd10, 4'd0, 4'd10, m);
    check({tag, " strobe"}, {63'd0, red_valid}, 64'd1);
    check({tag, " result"}, {63'd0, red_bit}, {63'd0, exp});
    @(negedge clk);
    check({tag, " strobe ends"}, {63'd0, red_valid | red_bit}, 64'd0);
    peek(4'd10, r);
    check({tag, " no write"}, r, v);
  endtask

  task automatic t_reduce;
    reduce_case("R6 all ones all-set", '1, 4'd7, 2'd0, 1'b1);
    reduce_case("R6 one clear bit in high half", 64'hFFFF_FFFE_FFFF_FFFF, 4'd7, 2'd0, 1'b0);
    reduce_case("R6 one clear bit in low half", 64'hFFFF_FFFF_7FFF_FFFF, 4'd7, 2'd0, 1'b0);
    reduce_case("R7 zero any-set", 64'd0, 4'd8, 2'd0, 1'b0);
    reduce_case("R7 top bit any-set", 64'h8000_0000_0000_0000, 4'd8, 2'd0, 1'b1);
    reduce_case("R8 even bits all-set mode1", 64'h5555_5555_5555_5555, 4'd7, 2'd1, 1'b1);
    reduce_case("R8 even bits all-set mode0", 64'h5555_5555_5555_5555, 4'd7, 2'd0, 1'b0);
    reduce_case("R8 odd bits any-set mode1", 64'hAAAA_AAAA_AAAA_AAAA, 4'd8, 2'd1, 1'b0);
    reduce_case("R8 quad bits all-set mode2", 64'h1111_1111_1111_1111, 4'd7, 2'd2, 1'b1);
    reduce_case("R8 bit63 any-set mode2", 64'h8000_0000_0000_0000, 4'd8, 2'd2, 1'b0);
    reduce_case("R8 bit60 any-set mode2", 64'h1000_0000_0000_0000, 4'd8, 2'd2, 1'b1);
  endtask

  task automatic t_mode3;
    issue(4'd8, 4'd1, 4'd0, 4'd0, 2'd3);
    check("R8 mode3 reduce illegal", {63'd0, illegal}, 64'd1);
    check("R8 mode3 no strobe", {63'd0, red_valid}, 64'd0);
  endtask

  task automatic t_priority;
    logic [63:0] r;
    issue(4'd2, 4'd1, 4'd2, 4'd8, 2'd0);
    ld_we = 1'b1; ld_idx = 4'd8; ld_data = 64'h5A5A_5A5A_5A5A_5A5A;
    peek(4'd8, r);
    check("R9 writeback beats load on read", r, VA ^ VB);
    @(negedge clk);
    ld_we = 1'b0;
    peek(4'd8, r);
    check("R9 writeback beats load in file", r, VA ^ VB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load();
    t_logic();
    t_andn_swap();
    t_back_to_back();
    t_illegal();
    t_reduce();
    t_mode3();
    t_priority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule